// File: doc/BRIEF.md
# Turbo Half-Iteration Scheduler

This block sequences a turbo decoder built around a single soft-in soft-out (SISO) engine and a single interleaver address path. It captures a frame's block size and iteration count when the frame opens, waits for the soft input to finish loading, and then starts the SISO engine once for each of the 2×iterations half-iterations. For every half-iteration it tells the engine which address order to walk (natural or interleaved), which parity stream to use, and whether the a-priori input must be forced to zero. Each half's extrinsic output is fed back as the next half's a-priori input.

When the final half-iteration completes, the block reads the a-posteriori LLR store in natural order and streams one hard-decision bit per valid cycle, with start on the first bit and end on the last. A ready output tells the upstream source when a new frame may be offered. The SISO arithmetic and the address formula are outside this block: the engine is reached through a go/done handshake, and the LLR store through a read port with one cycle of latency.

The controller states are IDLE (ready, waiting for a frame start), LOAD (input frame arriving), ISSUE (one-cycle engine start), WAIT (engine running) and OUT (hard-decision readout). Transitions: IDLE to LOAD on a valid start; LOAD to ISSUE on a valid end; ISSUE to WAIT always; WAIT to ISSUE on done when halves remain; WAIT to OUT on done of the final half; OUT to IDLE on the cycle after the output end pulse.

Top module: `turbo_hiter_sched`

## Requirements
- R1: Out of reset the block is in IDLE: ready is 1, and siso_go, llr_rd_en, out_valid, out_start and out_end are 0.
- R2: A cycle with in_start and in_valid both 1 while ready is 1 captures in_blk_size and in_iters; cfg_blk_size shows the captured size (0 becomes 1) from the next cycle and holds it until the next accepted frame, whatever in_blk_size does meanwhile. An in_iters value of 0 is treated as 1.
- R3: A start arriving while ready is 0 (during load, decoding or readout, including the cycle of out_end) is ignored: it changes neither cfg_blk_size nor the number of half-iterations or output bits.
- R4: The cycle after in_end and in_valid are seen in LOAD, siso_go pulses for one cycle; after each siso_done, another single-cycle pulse follows one cycle later until exactly 2×iterations pulses have been issued for the frame.
- R5: Half-iterations are numbered from 0. An even-numbered half drives siso_use_il=0 (natural order) and siso_par_sel=0 (first parity); an odd-numbered half drives siso_use_il=1 (interleaved order) and siso_par_sel=1 (second parity). These levels hold from the go pulse until done.
- R6: siso_apr_zero is 1 during half 0 only and 0 for every later half.
- R7: The cycle after the last siso_done, llr_rd_en is 1 for block-size consecutive cycles with llr_rd_addr stepping 0, 1, 2, ... up to block size − 1.
- R8: Each read produces one output two cycles after its llr_rd_en cycle: out_valid=1 and out_bit=1 when the two's-complement LLR is greater than zero, else 0; out_start marks the bit from address 0 and out_end the bit from the last address.
- R9: ready is 0 from the cycle after the frame is accepted up to and including the out_end cycle, and 1 again the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_start | input | 1 | First sample of an input frame |
| in_end | input | 1 | Last sample of an input frame |
| in_blk_size | input | BLK_W | Block size, sampled with the frame start |
| in_iters | input | ITER_W | Full iteration count, sampled with the frame start |
| ready | output | 1 | A new frame may be started |
| cfg_blk_size | output | BLK_W | Captured block size for the engine and interleaver |
| siso_go | output | 1 | One-cycle start for a half-iteration |
| siso_use_il | output | 1 | 1: interleaved address order, 0: natural |
| siso_par_sel | output | 1 | 1: second parity stream, 0: first |
| siso_apr_zero | output | 1 | Force the a-priori input to zero |
| siso_done | input | 1 | Engine finished the current half-iteration |
| llr_rd_en | output | 1 | Read strobe to the a-posteriori LLR store |
| llr_rd_addr | output | BLK_W | Natural-order read address |
| llr_rd_data | input | LLR_W | Signed LLR, valid one cycle after the strobe |
| out_valid | output | 1 | Hard-decision bit qualifier |
| out_start | output | 1 | First bit of the output frame |
| out_end | output | 1 | Last bit of the output frame |
| out_bit | output | 1 | Hard-decision bit |

## Verification
The interesting collision is a frame start that lands while the block is busy, most sharply in the very cycle that out_end is high, when ready is still low but about to rise. The bench holds in_start and in_valid high with a different block size throughout decoding and readout and releases them only in the out_end cycle, then checks that the captured size, the count of half-iteration pulses and the output bit count are those of the original frame and that ready returns to 1 with no new frame accepted. A second overlap, a stray start during LOAD, is judged the same way.

// File: rtl/ths_pkg.sv
package ths_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ISSUE,
        ST_WAIT,
        ST_OUT
    } ths_state_e;

    typedef struct packed {
        logic use_il;
        logic par_sel;
        logic apr_zero;
    } half_sel_t;

endpackage

// File: rtl/ths_cfg_latch.sv
module ths_cfg_latch #(
    parameter int BLK_W  = 13,
    parameter int ITER_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BLK_W-1:0]  blk_in,
    input  logic [ITER_W-1:0] iters_in,
    output logic [BLK_W-1:0]  blk_q,
    output logic [ITER_W-1:0] iters_q
);

    logic [BLK_W-1:0]  blk_fix;
    logic [ITER_W-1:0] iters_fix;

    always_comb begin
        blk_fix   = (blk_in == '0)   ? BLK_W'(1)  : blk_in;
        iters_fix = (iters_in == '0) ? ITER_W'(1) : iters_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q   <= BLK_W'(1);
            iters_q <= ITER_W'(1);
        end else if (capture) begin
            blk_q   <= blk_fix;
            iters_q <= iters_fix;
        end
    end

    // R2: a captured value is never zero
    p_cfg_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q != '0) && (iters_q != '0));

endmodule

// File: rtl/ths_half_sel.sv
module ths_half_sel
    import ths_pkg::*;
#(
    parameter int ITER_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [ITER_W-1:0] iters,
    output half_sel_t         sel,
    output logic              last
);

    localparam int HW = ITER_W + 1;

    logic [HW-1:0] half_cnt;
    logic [HW-1:0] last_idx;

    always_comb begin
        last_idx = {iters, 1'b0} - HW'(1);
        last     = (half_cnt == last_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
        end else if (clear) begin
            half_cnt <= '0;
        end else if (advance) begin
            half_cnt <= half_cnt + HW'(1);
        end
    end

    always_comb begin
        sel.use_il   = half_cnt[0];
        sel.par_sel  = half_cnt[0];
        sel.apr_zero = (half_cnt == '0);
    end

    // R4: the half counter never runs past the final half of the frame
    p_half_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |-> (half_cnt < last_idx));

endmodule

// File: rtl/ths_hd_stream.sv
module ths_hd_stream #(
    parameter int BLK_W = 13,
    parameter int LLR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [BLK_W-1:0]        blk,
    output logic                    rd_en,
    output logic [BLK_W-1:0]        rd_addr,
    input  logic signed [LLR_W-1:0] rd_data,
    output logic                    out_valid,
    output logic                    out_start,
    output logic                    out_end,
    output logic                    out_bit
);

    localparam int CW = BLK_W + 1;

    logic [CW-1:0] rd_cnt;
    logic [CW-1:0] blk_ext;
    logic          s1_valid;
    logic          s1_first;
    logic          s1_last;
    logic          llr_pos;

    always_comb begin
        blk_ext = {1'b0, blk};
        rd_en   = run && (rd_cnt < blk_ext);
        rd_addr = rd_cnt[BLK_W-1:0];
        llr_pos = !rd_data[LLR_W-1] && (rd_data != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt <= '0;
        end else if (!run) begin
            rd_cnt <= '0;
        end else if (rd_en) begin
            rd_cnt <= rd_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_first  <= 1'b0;
            s1_last   <= 1'b0;
            out_valid <= 1'b0;
            out_start <= 1'b0;
            out_end   <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            s1_valid  <= rd_en;
            s1_first  <= rd_en && (rd_cnt == '0);
            s1_last   <= rd_en && (rd_cnt == blk_ext - CW'(1));
            out_valid <= s1_valid;
            out_start <= s1_first;
            out_end   <= s1_last;
            out_bit   <= s1_valid && llr_pos;
        end
    end

    // R8: framing marks only ever sit on a valid bit
    p_mark_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_start || out_end) |-> out_valid);

    // R8: each output bit follows its read strobe by two cycles
    p_out_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rd_en, 2));

    // R7: addresses step by one between consecutive reads
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + BLK_W'(1)));

endmodule

// File: rtl/turbo_hiter_sched.sv
module turbo_hiter_sched
    import ths_pkg::*;
#(
    parameter int BLK_W  = 13,
    parameter int ITER_W = 4,
    parameter int LLR_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_start,
    input  logic                    in_end,
    input  logic [BLK_W-1:0]        in_blk_size,
    input  logic [ITER_W-1:0]       in_iters,
    output logic                    ready,
    output logic [BLK_W-1:0]        cfg_blk_size,
    output logic                    siso_go,
    output logic                    siso_use_il,
    output logic                    siso_par_sel,
    output logic                    siso_apr_zero,
    input  logic                    siso_done,
    output logic                    llr_rd_en,
    output logic [BLK_W-1:0]        llr_rd_addr,
    input  logic signed [LLR_W-1:0] llr_rd_data,
    output logic                    out_valid,
    output logic                    out_start,
    output logic                    out_end,
    output logic                    out_bit
);

    ths_state_e        state_q;
    ths_state_e        state_d;
    logic              capture;
    logic              half_adv;
    logic              half_last;
    logic              stream_run;
    logic [ITER_W-1:0] iters_q;
    half_sel_t         sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid && in_start) state_d = ST_LOAD;
            ST_LOAD:  if (in_valid && in_end)   state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (siso_done) state_d = half_last ? ST_OUT : ST_ISSUE;
            ST_OUT:   if (out_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        ready      = (state_q == ST_IDLE);
        siso_go    = (state_q == ST_ISSUE);
        stream_run = (state_q == ST_OUT);
        capture    = (state_q == ST_IDLE) && in_valid && in_start;
        half_adv   = (state_q == ST_WAIT) && siso_done && !half_last;
    end

    ths_cfg_latch #(
        .BLK_W  (BLK_W),
        .ITER_W (ITER_W)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .blk_in   (in_blk_size),
        .iters_in (in_iters),
        .blk_q    (cfg_blk_size),
        .iters_q  (iters_q)
    );

    ths_half_sel #(
        .ITER_W (ITER_W)
    ) half_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (capture),
        .advance (half_adv),
        .iters   (iters_q),
        .sel     (sel),
        .last    (half_last)
    );

    always_comb begin
        siso_use_il   = sel.use_il;
        siso_par_sel  = sel.par_sel;
        siso_apr_zero = sel.apr_zero;
    end

    ths_hd_stream #(
        .BLK_W (BLK_W),
        .LLR_W (LLR_W)
    ) stream_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (stream_run),
        .blk       (cfg_blk_size),
        .rd_en     (llr_rd_en),
        .rd_addr   (llr_rd_addr),
        .rd_data   (llr_rd_data),
        .out_valid (out_valid),
        .out_start (out_start),
        .out_end   (out_end),
        .out_bit   (out_bit)
    );

    // R4: each engine start lasts a single cycle
    p_go_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        siso_go |=> !siso_go);

    // R9: ready is low in the end cycle and back the cycle after
    p_ready_end_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> !ready);
    p_ready_end_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |=> ready);

    // R2: captured size holds while the block is busy
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !$past(ready)) |-> $stable(cfg_blk_size));

    // R6: the zero a-priori half is always a natural-order half
    p_apr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (siso_go && siso_apr_zero) |-> (!siso_use_il && !siso_par_sel));

    // R7: LLR reads never overlap engine starts or idle time
    p_rd_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        llr_rd_en |-> (!siso_go && !ready));

    // R5: selection is held steady while the engine runs
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q) == ST_WAIT)
            |-> ($stable(siso_use_il) && $stable(siso_par_sel)));

endmodule

// File: tb/turbo_hiter_sched_tb_top.sv
module turbo_hiter_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BLK_W      = 13;
    localparam int ITER_W     = 4;
    localparam int LLR_W      = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_start = 1'b0;
    logic                    in_end = 1'b0;
    logic [BLK_W-1:0]        in_blk_size = '0;
    logic [ITER_W-1:0]       in_iters = '0;
    logic                    ready;
    logic [BLK_W-1:0]        cfg_blk_size;
    logic                    siso_go;
    logic                    siso_use_il;
    logic                    siso_par_sel;
    logic                    siso_apr_zero;
    logic                    siso_done = 1'b0;
    logic                    llr_rd_en;
    logic [BLK_W-1:0]        llr_rd_addr;
    logic signed [LLR_W-1:0] llr_rd_data = '0;
    logic                    out_valid;
    logic                    out_start;
    logic                    out_end;
    logic                    out_bit;

    turbo_hiter_sched #(
        .BLK_W (BLK_W), .ITER_W (ITER_W), .LLR_W (LLR_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_start (in_start), .in_end (in_end),
        .in_blk_size (in_blk_size), .in_iters (in_iters),
        .ready (ready), .cfg_blk_size (cfg_blk_size),
        .siso_go (siso_go), .siso_use_il (siso_use_il),
        .siso_par_sel (siso_par_sel), .siso_apr_zero (siso_apr_zero),
        .siso_done (siso_done),
        .llr_rd_en (llr_rd_en), .llr_rd_addr (llr_rd_addr),
        .llr_rd_data (llr_rd_data),
        .out_valid (out_valid), .out_start (out_start),
        .out_end (out_end), .out_bit (out_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard queues
    int half_q[$];   // {apr_zero, use_il, par_sel}
    bit bit_q[$];
    int len_q[$];

    // LLR store stub, one cycle read latency
    logic signed [LLR_W-1:0] llr_mem [0:63];
    always @(posedge clk) begin
        if (llr_rd_en) llr_rd_data <= llr_mem[llr_rd_addr[5:0]];
    end

    // SISO engine stub
    int siso_cnt = 0;
    bit siso_pend = 1'b0;
    always @(posedge clk) begin
        siso_done <= 1'b0;
        if (siso_go) begin
            siso_pend <= 1'b1;
            siso_cnt  <= 3;
        end else if (siso_pend) begin
            if (siso_cnt == 0) begin
                siso_done <= 1'b1;
                siso_pend <= 1'b0;
            end else begin
                siso_cnt <= siso_cnt - 1;
            end
        end
    end

    // monitor
    int go_sel = 0;
    int out_pos = 0;
    int rd_pos = 0;
    bit end_prev = 1'b0;
    int go_count = 0;
    int bit_count = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (siso_go) begin
                go_count++;
                go_sel = {29'd0, siso_apr_zero, siso_use_il, siso_par_sel};
                if (half_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected half-iteration start", go_count, 0);
                end else begin
                    int e;
                    e = half_q.pop_front();
                    chk(go_sel[2:1] == e[2:1], "R5 order/parity of half", go_sel, e);
                    chk(go_sel[2] == e[2], "R6 a-priori zero flag", go_sel[2], e[2]);
                    chk(go_sel[0] == e[0], "R5 parity select", go_sel[0], e[0]);
                end
            end
            if (siso_done) begin
                int cur;
                cur = {29'd0, siso_apr_zero, siso_use_il, siso_par_sel};
                chk(cur == go_sel, "R5 selection held until done", cur, go_sel);
            end
            if (llr_rd_en) begin
                chk(int'(llr_rd_addr) == rd_pos, "R7 read address order",
                    int'(llr_rd_addr), rd_pos);
                rd_pos++;
                if (len_q.size() > 0 && rd_pos == len_q[0]) rd_pos = 0;
            end
            if (out_valid) begin
                bit_count++;
                if (bit_q.size() == 0 || len_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected output bit", bit_count, 0);
                end else begin
                    bit eb;
                    int ln;
                    eb = bit_q.pop_front();
                    ln = len_q[0];
                    chk(out_bit == eb, "R8 hard decision", out_bit, eb);
                    chk(out_start == (out_pos == 0), "R8 start mark", out_start, out_pos == 0);
                    chk(out_end == (out_pos == ln - 1), "R8 end mark", out_end, out_pos == ln - 1);
                    out_pos++;
                    if (out_pos == ln) begin
                        out_pos = 0;
                        void'(len_q.pop_front());
                    end
                end
            end
            if (out_end) begin
                chk(!ready, "R9 ready low in end cycle", ready, 0);
            end else if (end_prev) begin
                chk(ready, "R9 ready back after end", ready, 1);
            end
            end_prev = out_end;
        end
    end

    task automatic run_frame(input int blk, input int iters, input int seed,
                             input bit flood);
        int eb;
        int ei;
        eb = (blk == 0) ? 1 : blk;
        ei = (iters == 0) ? 1 : iters;
        for (int i = 0; i < eb; i++) begin
            int v;
            v = ((i * 37 + seed * 11) % 256) - 128;
            if (i % 7 == 3) v = 0;
            if (i % 11 == 5) v = 1;
            if (i % 13 == 6) v = -1;
            llr_mem[i] = LLR_W'(v);
            bit_q.push_back(v > 0);
        end
        len_q.push_back(eb);
        for (int h = 0; h < 2 * ei; h++) begin
            int a;
            a = (h == 0) ? 4 : 0;
            half_q.push_back(a | ((h % 2) * 3));
        end
        go_count = 0;
        bit_count = 0;
        while (!ready) @(negedge clk);
        in_valid    = 1'b1;
        in_start    = 1'b1;
        in_blk_size = BLK_W'(blk);
        in_iters    = ITER_W'(iters);
        @(negedge clk);
        chk(!ready, "R9 ready drops after accept", ready, 0);
        chk(int'(cfg_blk_size) == eb, "R2 captured block size", int'(cfg_blk_size), eb);
        in_start    = 1'b0;
        in_blk_size = BLK_W'(blk + 9);
        in_iters    = 4'd7;
        @(negedge clk);
        in_start = 1'b1;            // stray start during load
        @(negedge clk);
        in_start = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_end   = 1'b1;
        @(negedge clk);
        in_end   = 1'b0;
        in_valid = 1'b0;
        chk(int'(cfg_blk_size) == eb, "R3 start during load ignored",
            int'(cfg_blk_size), eb);
        if (flood) begin
            in_valid = 1'b1;
            in_start = 1'b1;
        end
        while (!out_end) @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
        chk(int'(cfg_blk_size) == eb, "R3 size kept through busy starts",
            int'(cfg_blk_size), eb);
        @(negedge clk);
        chk(ready, "R9 ready after frame", ready, 1);
        repeat (4) @(negedge clk);
        chk(ready, "R3 no frame taken from busy start", ready, 1);
        chk(go_count == 2 * ei, "R4 half-iteration count", go_count, 2 * ei);
        chk(half_q.size() == 0, "R4 all halves issued", half_q.size(), 0);
        chk(bit_count == eb, "R7 output bit count", bit_count, eb);
        chk(bit_q.size() == 0, "R8 all bits produced", bit_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(ready, "R1 reset ready", ready, 1);
        chk(!siso_go, "R1 reset go", siso_go, 0);
        chk(!llr_rd_en, "R1 reset read", llr_rd_en, 0);
        chk(!out_valid && !out_start && !out_end, "R1 reset framing",
            {out_valid, out_start, out_end}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready, "R1 idle after reset", ready, 1);
        run_frame(6, 2, 1, 1'b0);
        run_frame(3, 0, 2, 1'b1);
        run_frame(0, 15, 3, 1'b1);
        run_frame(40, 1, 4, 1'b0);
        run_frame(17, 3, 5, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule